// File: doc/BRIEF.md
# CAN controller interrupt aggregator

This block sits beside a CAN-style bus controller and turns the controller's scattered event indications into one raw interrupt status byte and a single level-sensitive interrupt line for the host. It watches seven sources: pending received messages, the transmit buffer becoming free, changes in the error and bus-off flags, data overrun, error passive, arbitration lost and bus error.

The host reads the status byte through a one-cycle read strobe. The read returns the byte as it stood and clears every event bit. The receive bit is the exception. It mirrors whether the pending-message count is nonzero, and that count covers both valid and overrun messages. The bit therefore falls only when the host has released every pending message. A small transmit tracker, `irq_tx_free_fsm`, works out when the transmit buffer becomes free. Its state `TX_IDLE` moves to `TX_ACTIVE` on the transition START. From `TX_ACTIVE` it returns to `TX_IDLE` on DONE_OK (acknowledged success), DONE_SINGLE (a single-shot attempt finished, good or bad) or ABORT (abort command). It stays in `TX_ACTIVE` on RETRY, which is a failed attempt that is not single-shot. A per-bit enable byte selects which raw bits drive the interrupt line.

Top module: `can_irq_aggregator`

## Requirements
- R1: `irq` is high exactly when some raw status bit and its enable bit are both set. It is low when no enabled raw bit is set.
- R2: A read strobe on `rd_en` makes `rd_data` show the raw status byte as it stood at that edge, with `rd_valid` high for one cycle after the edge. The same edge clears raw bits 1, 2, 3, 5, 6 and 7.
- R3: Raw bit 0 (receive) is 1 one cycle after `rx_pending_cnt` is nonzero and 0 one cycle after it is zero. A read never clears it.
- R4: An acknowledged success (`tx_ack_ok`) while a transmission is active sets raw bit 1 (transmit) and ends the transmission.
- R5: A failure (`tx_fail`) while active sets raw bit 1 if `tx_single_shot` is high. Otherwise the transmission stays active for a retry and bit 1 is not set. Completion inputs outside an active transmission set nothing.
- R6: An abort (`tx_abort`) while a transmission is active sets raw bit 1 and ends the transmission. Abort takes priority over success, and success takes priority over failure.
- R7: Any change of `err_st` or `bus_off_st` from its value in the previous cycle sets raw bit 2 (error warning). Both flags are taken as 0 at reset.
- R8: Pulses on `ev_overrun`, `ev_err_passive`, `ev_arb_lost` and `ev_bus_err` set raw bits 3, 5, 6 and 7 respectively.
- R9: An event arriving in the same cycle as a read leaves its bit set after the read. The read data shows the value from before that event.
- R10: Raw bit 4 always reads 0. An enable write (`ien_wr`) changes only the gating of `irq`, never the raw status byte.
- R11: Reset clears the raw status byte and `rd_valid`, sets all enables to 1, and puts the transmit tracker in `TX_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pending_cnt | input | CNT_W | Pending received-message count (valid plus overrun) |
| tx_start | input | 1 | A transmission begins |
| tx_ack_ok | input | 1 | Transmission acknowledged without error |
| tx_fail | input | 1 | Transmission attempt failed |
| tx_single_shot | input | 1 | Current transmission is single-shot |
| tx_abort | input | 1 | Abort command for the current transmission |
| err_st | input | 1 | Error-status flag level |
| bus_off_st | input | 1 | Bus-off flag level |
| ev_overrun | input | 1 | Data overrun event pulse |
| ev_err_passive | input | 1 | Error passive event pulse |
| ev_arb_lost | input | 1 | Arbitration lost event pulse |
| ev_bus_err | input | 1 | Bus error event pulse |
| rd_en | input | 1 | Status read strobe |
| rd_data | output | 8 | Status byte captured by the last read |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| ien_wr | input | 1 | Enable byte write strobe |
| ien_wdata | input | 8 | Enable byte write value |
| irq | output | 1 | Level interrupt to the host |

## Verification
A table of vectors drives each event source alone, then several together, and checks each resulting byte with a clearing read. This separates a wrong bit position from a missing set or a missing clear. The transmit vectors run success, single-shot failure, plain failure with retry followed by a later success, abort, and completion inputs with no transmission active. This shows whether the tracker keeps retries quiet and ignores stray completions. The error-flag vectors toggle one flag, then both, then neither, to tell edge detection apart from level following. Directed cases cover enable masking against the raw byte, an event that coincides with a read, a receive bit that outlives reads, and reset in mid-run.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int STAT_W   = 8;
    localparam int BIT_RX   = 0;
    localparam int BIT_TX   = 1;
    localparam int BIT_EW   = 2;
    localparam int BIT_OVR  = 3;
    localparam int BIT_PAS  = 5;
    localparam int BIT_ARB  = 6;
    localparam int BIT_BERR = 7;

    localparam logic [STAT_W-1:0] IMPL_MASK =
        STAT_W'((1 << BIT_RX) | (1 << BIT_TX) | (1 << BIT_EW) | (1 << BIT_OVR) |
                (1 << BIT_PAS) | (1 << BIT_ARB) | (1 << BIT_BERR));

    typedef enum logic [0:0] {
        TX_IDLE   = 1'b0,
        TX_ACTIVE = 1'b1
    } tx_state_e;

endpackage

// File: rtl/irq_tx_free_fsm.sv
module irq_tx_free_fsm
    import can_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_start,
    input  logic tx_ack_ok,
    input  logic tx_fail,
    input  logic tx_single_shot,
    input  logic tx_abort,
    output logic tx_free,
    output logic tx_busy
);

    tx_state_e state_q;
    tx_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state: START, ABORT, DONE_OK, DONE_SINGLE, RETRY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (tx_start) state_d = TX_ACTIVE;
            end
            TX_ACTIVE: begin
                if (tx_abort)                       state_d = TX_IDLE;
                else if (tx_ack_ok)                 state_d = TX_IDLE;
                else if (tx_fail && tx_single_shot) state_d = TX_IDLE;
                else                                state_d = TX_ACTIVE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_free = 1'b0;
        tx_busy = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                tx_free = 1'b0;
                tx_busy = 1'b0;
            end
            TX_ACTIVE: begin
                tx_busy = 1'b1;
                tx_free = tx_abort | tx_ack_ok | (tx_fail & tx_single_shot);
            end
            default: begin
                tx_free = 1'b0;
                tx_busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/irq_err_watch.sv
module irq_err_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic err_st,
    input  logic bus_off_st,
    output logic err_prev,
    output logic bo_prev,
    output logic ew_set
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_prev <= 1'b0;
            bo_prev  <= 1'b0;
        end else begin
            err_prev <= err_st;
            bo_prev  <= bus_off_st;
        end
    end

    always_comb ew_set = (err_st ^ err_prev) | (bus_off_st ^ bo_prev);

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              rx_level,
    input  logic              rd_clr,
    output logic [STAT_W-1:0] raw_q
);

    logic [STAT_W-1:0] raw_d;

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b == BIT_RX) begin : g_rx
            always_comb raw_d[b] = rx_level;
        end else if (IMPL_MASK[b]) begin : g_evt
            always_comb raw_d[b] = (raw_q[b] & ~rd_clr) | set_vec[b];
        end else begin : g_none
            always_comb raw_d[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

endmodule

// File: rtl/can_irq_aggregator.sv
module can_irq_aggregator
    import can_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_pending_cnt,
    input  logic             tx_start,
    input  logic             tx_ack_ok,
    input  logic             tx_fail,
    input  logic             tx_single_shot,
    input  logic             tx_abort,
    input  logic             err_st,
    input  logic             bus_off_st,
    input  logic             ev_overrun,
    input  logic             ev_err_passive,
    input  logic             ev_arb_lost,
    input  logic             ev_bus_err,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             ien_wr,
    input  logic [7:0]       ien_wdata,
    output logic             irq
);

    logic              tx_free;
    logic              tx_busy;
    logic              err_prev;
    logic              bo_prev;
    logic              ew_set;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] raw_q;
    logic [STAT_W-1:0] ien_q;
    logic [STAT_W-1:0] rd_data_q;
    logic              rd_valid_q;

    irq_tx_free_fsm u_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_start       (tx_start),
        .tx_ack_ok      (tx_ack_ok),
        .tx_fail        (tx_fail),
        .tx_single_shot (tx_single_shot),
        .tx_abort       (tx_abort),
        .tx_free        (tx_free),
        .tx_busy        (tx_busy)
    );

    irq_err_watch u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_st     (err_st),
        .bus_off_st (bus_off_st),
        .err_prev   (err_prev),
        .bo_prev    (bo_prev),
        .ew_set     (ew_set)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[BIT_TX]   = tx_free;
        set_vec[BIT_EW]   = ew_set;
        set_vec[BIT_OVR]  = ev_overrun;
        set_vec[BIT_PAS]  = ev_err_passive;
        set_vec[BIT_ARB]  = ev_arb_lost;
        set_vec[BIT_BERR] = ev_bus_err;
    end

    irq_status_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .rx_level (|rx_pending_cnt),
        .rd_clr   (rd_en),
        .raw_q    (raw_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q      <= IMPL_MASK;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            if (ien_wr) ien_q <= ien_wdata & IMPL_MASK;
            rd_valid_q <= rd_en;
            if (rd_en) rd_data_q <= raw_q;
        end
    end

    always_comb begin
        rd_data  = rd_data_q;
        rd_valid = rd_valid_q;
        irq      = |(raw_q & ien_q);
    end

endmodule

// File: rtl/can_irq_aggregator_chk.sv
module can_irq_aggregator_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_pending_cnt,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [7:0]       raw,
    input logic             err_st,
    input logic             bus_off_st,
    input logic             err_prev,
    input logic             bo_prev,
    input logic             tx_busy,
    input logic             tx_free,
    input logic             ew_set,
    input logic             ev_overrun,
    input logic             ev_err_passive,
    input logic             ev_arb_lost,
    input logic             ev_bus_err
);

    p_rx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pending_cnt != '0) |=> raw[0]);

    p_rx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pending_cnt == '0) |=> !raw[0]);

    p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !tx_free && !ew_set && !ev_overrun && !ev_err_passive &&
         !ev_arb_lost && !ev_bus_err) |=> (raw[7:1] == 7'd0));

    p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_idle_no_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !tx_free);

    p_ew_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_st != err_prev) || (bus_off_st != bo_prev)) |=> raw[2]);

    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ev_overrun) |=> raw[3]);

endmodule

bind can_irq_aggregator can_irq_aggregator_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_pending_cnt (rx_pending_cnt),
    .rd_en          (rd_en),
    .rd_valid       (rd_valid),
    .raw            (raw_q),
    .err_st         (err_st),
    .bus_off_st     (bus_off_st),
    .err_prev       (err_prev),
    .bo_prev        (bo_prev),
    .tx_busy        (tx_busy),
    .tx_free        (tx_free),
    .ew_set         (ew_set),
    .ev_overrun     (ev_overrun),
    .ev_err_passive (ev_err_passive),
    .ev_arb_lost    (ev_arb_lost),
    .ev_bus_err     (ev_bus_err)
);

// File: tb/test_can_irq_aggregator.sv
module test_can_irq_aggregator;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 7;
    localparam int NVEC       = 22;

    // vector: cnt[22:19] start ok fail ss abort err bo ovr pas arb berr [18:8], expected read [7:0]
    localparam logic [22:0] VECS [NVEC] = '{
        {4'd0, 11'b000_0000_0000, 8'h00},  // idle
        {4'd0, 11'b110_0000_0000, 8'h02},  // R4 success
        {4'd0, 11'b101_1000_0000, 8'h02},  // R5 single-shot fail
        {4'd0, 11'b101_0000_0000, 8'h00},  // R5 retry, stays active
        {4'd0, 11'b010_0000_0000, 8'h02},  // R4 success after retry
        {4'd0, 11'b100_0100_0000, 8'h02},  // R6 abort
        {4'd0, 11'b000_0010_0000, 8'h04},  // R7 err rises
        {4'd0, 11'b000_0011_0000, 8'h04},  // R7 bus-off rises
        {4'd0, 11'b000_0011_0000, 8'h00},  // R7 no change
        {4'd0, 11'b000_0000_0000, 8'h04},  // R7 both fall
        {4'd0, 11'b000_0000_1000, 8'h08},  // R8 overrun
        {4'd0, 11'b000_0000_0100, 8'h20},  // R8 passive
        {4'd0, 11'b000_0000_0010, 8'h40},  // R8 arb lost
        {4'd0, 11'b000_0000_0001, 8'h80},  // R8 bus err
        {4'd3, 11'b000_0000_0000, 8'h01},  // R3 pending
        {4'd3, 11'b000_0000_1100, 8'h29},  // R3 R8 mix
        {4'd3, 11'b000_0000_0000, 8'h01},  // R3 survives read
        {4'd0, 11'b000_0000_0000, 8'h00},  // R3 released
        {4'd0, 11'b001_1000_0000, 8'h00},  // R5 fail while idle
        {4'd0, 11'b000_0100_0000, 8'h00},  // R6 abort while idle
        {4'd1, 11'b110_0010_1111, 8'hEF},  // R10 all sources
        {4'd0, 11'b000_0000_0000, 8'h04}   // R7 err falls
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] rx_pending_cnt = '0;
    logic             tx_start = 1'b0, tx_ack_ok = 1'b0, tx_fail = 1'b0;
    logic             tx_single_shot = 1'b0, tx_abort = 1'b0;
    logic             err_st = 1'b0, bus_off_st = 1'b0;
    logic             ev_overrun = 1'b0, ev_err_passive = 1'b0;
    logic             ev_arb_lost = 1'b0, ev_bus_err = 1'b0;
    logic             rd_en = 1'b0;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             ien_wr = 1'b0;
    logic [7:0]       ien_wdata = 8'h00;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_irq_aggregator #(.CNT_W(CNT_W)) i_can_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .rx_pending_cnt(rx_pending_cnt),
        .tx_start(tx_start), .tx_ack_ok(tx_ack_ok), .tx_fail(tx_fail),
        .tx_single_shot(tx_single_shot), .tx_abort(tx_abort),
        .err_st(err_st), .bus_off_st(bus_off_st), .ev_overrun(ev_overrun),
        .ev_err_passive(ev_err_passive), .ev_arb_lost(ev_arb_lost),
        .ev_bus_err(ev_bus_err), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .ien_wr(ien_wr), .ien_wdata(ien_wdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_pulses();
        tx_start = 0; tx_ack_ok = 0; tx_fail = 0; tx_single_shot = 0; tx_abort = 0;
        ev_overrun = 0; ev_err_passive = 0; ev_arb_lost = 0; ev_bus_err = 0;
        rd_en = 0; ien_wr = 0;
    endtask

    task automatic do_read(input string req, input logic [7:0] exp);
        rd_en = 1;
        step();
        rd_en = 0;
        check(req, {7'd0, rd_valid}, 8'h01);
        check(req, rd_data, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        check("R11 irq in reset", {7'd0, irq}, 8'h00);
        check("R11 rd_valid in reset", {7'd0, rd_valid}, 8'h00);
        rst_n = 1;
        step();
        do_read("R11 status after reset", 8'h00);

        // vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [22:0] v;
            v = VECS[i];
            rx_pending_cnt = CNT_W'(v[22:19]);
            tx_start = v[18];
            step();
            tx_start = 0;
            tx_ack_ok = v[17]; tx_fail = v[16]; tx_single_shot = v[15];
            tx_abort = v[14]; err_st = v[13]; bus_off_st = v[12];
            ev_overrun = v[11]; ev_err_passive = v[10];
            ev_arb_lost = v[9]; ev_bus_err = v[8];
            step();
            clear_pulses();
            do_read($sformatf("R2 vector %0d", i), v[7:0]);
        end

        // R1 interrupt line follows an enabled bit
        ev_overrun = 1;
        step();
        ev_overrun = 0;
        check("R1 irq raised", {7'd0, irq}, 8'h01);
        // R10 enable write masks line, not raw byte
        ien_wr = 1; ien_wdata = 8'hF7;
        step();
        ien_wr = 0;
        check("R10 irq masked", {7'd0, irq}, 8'h00);
        do_read("R10 raw unmasked", 8'h08);
        ien_wr = 1; ien_wdata = 8'hFF;
        step();
        ien_wr = 0;
        check("R1 irq low when clear", {7'd0, irq}, 8'h00);

        // R9 event coincident with read
        rd_en = 1; ev_overrun = 1;
        step();
        clear_pulses();
        check("R9 read shows old value", rd_data, 8'h00);
        check("R9 irq kept", {7'd0, irq}, 8'h01);
        do_read("R9 bit survived", 8'h08);

        // R3 receive bit holds irq across reads
        rx_pending_cnt = 2;
        step();
        check("R3 irq from pending", {7'd0, irq}, 8'h01);
        do_read("R3 read pending", 8'h01);
        check("R3 irq after read", {7'd0, irq}, 8'h01);
        rx_pending_cnt = 0;
        step();
        check("R3 irq after release", {7'd0, irq}, 8'h00);

        // R11 reset mid-run
        ev_bus_err = 1;
        step();
        ev_bus_err = 0;
        check("R11 irq before reset", {7'd0, irq}, 8'h01);
        rst_n = 0;
        #1;
        check("R11 irq in mid reset", {7'd0, irq}, 8'h00);
        step();
        rst_n = 1;
        step();
        do_read("R11 status after mid reset", 8'h00);

        finish_run();
    end

endmodule